// File: doc/BRIEF.md
# Execute-in-Place Address Translator

This block sits between an execute-in-place fetch path and a serial flash controller. It turns each 25-bit virtual address into a 24-bit physical flash address. The virtual space is split into eight windows of 4 MiB each. Every window has its own relocation base and its own aperture limit. Both are counted in 4 KiB sectors. This lets one program image run from several physical flash locations without any address fix-up in software.

A request is accepted on a valid/ready handshake. One cycle later the block returns a registered response. The response carries either a physical address or an error flag. The error flag means the request fell outside its window's aperture and must not reach the flash. A simple write port loads the base and limit of one window per cycle. After reset, every window maps virtual addresses onto identical physical addresses.

Top module: `xip_addr_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Window n holds a base of (n×0x400) mod 0x1000 and a limit of 0x400. As a result, every in-range virtual address translates to its own low 24 bits.
- R2: The window that serves a request is selected by `req_vaddr[24:22]`.
- R3: The sector number inside a window is s = `req_vaddr[21:12]`. If the request is in range, `rsp_paddr[23:12]` = (s + base) mod 0x1000 and `rsp_paddr[11:0]` = `req_vaddr[11:0]`.
- R4: The sector addition wraps modulo 16 MiB. Any carry out of bit 23 is dropped.
- R5: `rsp_err` is 1 exactly when s is greater than the window's limit. A sector equal to the limit is in range. When `rsp_err` is 1, `rsp_paddr` is 0.
- R6: A write with `cfg_we`=1 loads `cfg_base` and `cfg_limit` into window `cfg_win` at that clock edge. Requests accepted at that same edge still use the old values. The other windows are unchanged.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears with `rsp_valid`=1 right after that edge.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0. During that time `rsp_paddr` and `rsp_err` hold their values.
- R9: While `rsp_ready` stays 1, one request is accepted and answered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_win | input | 3 | Window selected by the write |
| cfg_base | input | 12 | New relocation base, in 4 KiB sectors |
| cfg_limit | input | 11 | New aperture limit, in 4 KiB sectors |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 25 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical address (0 when out of range) |
| rsp_err | output | 1 | Aperture violation |

## Verification
The response to a request accepted at edge k is due right after edge k. A configuration write at edge k only affects requests accepted at edge k+1 or later. `req_ready` depends on the current inputs within the same cycle. The bench drives inputs at the falling edge and checks `req_ready` shortly after. A reference model then advances at the rising edge, using the inputs that were present at that edge. One time unit after the edge, the bench compares `rsp_valid`, `rsp_paddr` and `rsp_err` against that model, every cycle.

// File: rtl/xip_xlate_pkg.sv
package xip_xlate_pkg;
   localparam int DEF_NUM_WIN   = 8;
   localparam int DEF_WIN_BITS  = 22;
   localparam int DEF_PAGE_BITS = 12;
   localparam int DEF_PHYS_BITS = 24;

   // identity base of window idx: its first sector, wrapped to the base width
   function automatic int ident_base(input int idx, input int off_w, input int base_w);
      return (idx * (1 << off_w)) % (1 << base_w);
   endfunction
endpackage

// File: rtl/xlate_win_regs.sv
module xlate_win_regs #(
   parameter int NUM_WIN = 8,
   parameter int IDX_W   = 3,
   parameter int OFF_W   = 10,
   parameter int BASE_W  = 12,
   parameter int LIM_W   = 11
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 win,
   input  logic [BASE_W-1:0]                base_in,
   input  logic [LIM_W-1:0]                 lim_in,
   output logic [NUM_WIN-1:0][BASE_W-1:0]   base_tbl,
   output logic [NUM_WIN-1:0][LIM_W-1:0]    lim_tbl
);
   import xip_xlate_pkg::*;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [BASE_W-1:0] RST_BASE = BASE_W'(ident_base(i, OFF_W, BASE_W));
      localparam logic [LIM_W-1:0]  RST_LIM  = LIM_W'(1 << OFF_W);
      logic hit;
      assign hit = we && (win == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_tbl[i] <= RST_BASE;
            lim_tbl[i]  <= RST_LIM;
         end else if (hit) begin
            base_tbl[i] <= base_in;
            lim_tbl[i]  <= lim_in;
         end
      end

      // R6
      win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && win == IDX_W'(i)) |=> (base_tbl[i] == $past(base_in) && lim_tbl[i] == $past(lim_in)));
      // R6
      win_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && win == IDX_W'(i)) |=> ($stable(base_tbl[i]) && $stable(lim_tbl[i])));
   end
endmodule

// File: rtl/xlate_calc.sv
module xlate_calc #(
   parameter int NUM_WIN   = 8,
   parameter int IDX_W     = 3,
   parameter int VADDR_W   = 25,
   parameter int WIN_BITS  = 22,
   parameter int PAGE_BITS = 12,
   parameter int OFF_W     = 10,
   parameter int BASE_W    = 12,
   parameter int LIM_W     = 11,
   parameter int PHYS_BITS = 24
) (
   input  logic [VADDR_W-1:0]               vaddr,
   input  logic [NUM_WIN-1:0][BASE_W-1:0]   base_tbl,
   input  logic [NUM_WIN-1:0][LIM_W-1:0]    lim_tbl,
   output logic [PHYS_BITS-1:0]             paddr,
   output logic                             err
);
   logic [IDX_W-1:0]     idx;
   logic [OFF_W-1:0]     sect;
   logic [BASE_W-1:0]    sum;
   logic [LIM_W-1:0]     lim;

   always_comb begin
      idx  = vaddr[VADDR_W-1 -: IDX_W];
      sect = vaddr[WIN_BITS-1:PAGE_BITS];
      lim  = lim_tbl[idx];
      sum  = BASE_W'(sect) + base_tbl[idx];
      err  = LIM_W'(sect) > lim;
      if (err) paddr = '0;
      else     paddr = {sum, vaddr[PAGE_BITS-1:0]};
   end
endmodule

// File: rtl/xlate_out_stage.sv
module xlate_out_stage #(
   parameter int W = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   // R7
   take_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: rtl/xip_addr_xlate.sv
module xip_addr_xlate #(
   parameter int NUM_WIN   = xip_xlate_pkg::DEF_NUM_WIN,
   parameter int WIN_BITS  = xip_xlate_pkg::DEF_WIN_BITS,
   parameter int PAGE_BITS = xip_xlate_pkg::DEF_PAGE_BITS,
   parameter int PHYS_BITS = xip_xlate_pkg::DEF_PHYS_BITS,
   localparam int IDX_W    = $clog2(NUM_WIN),
   localparam int VADDR_W  = WIN_BITS + IDX_W,
   localparam int OFF_W    = WIN_BITS - PAGE_BITS,
   localparam int BASE_W   = PHYS_BITS - PAGE_BITS,
   localparam int LIM_W    = OFF_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_win,
   input  logic [BASE_W-1:0]    cfg_base,
   input  logic [LIM_W-1:0]     cfg_limit,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [VADDR_W-1:0]   req_vaddr,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [PHYS_BITS-1:0] rsp_paddr,
   output logic                 rsp_err
);
   if (NUM_WIN < 2 || (1 << IDX_W) != NUM_WIN) begin : g_bad_win
      $error("NUM_WIN must be a power of two of at least 2");
   end
   if (PAGE_BITS >= WIN_BITS) begin : g_bad_page
      $error("sector size must be smaller than a window");
   end
   if (PHYS_BITS < WIN_BITS) begin : g_bad_phys
      $error("physical space must hold at least one window");
   end

   localparam int RSP_W = PHYS_BITS + 1;

   logic [NUM_WIN-1:0][BASE_W-1:0] base_tbl;
   logic [NUM_WIN-1:0][LIM_W-1:0]  lim_tbl;
   logic [PHYS_BITS-1:0]           calc_paddr;
   logic                           calc_err;
   logic [RSP_W-1:0]               rsp_word;

   xlate_win_regs #(
      .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .OFF_W(OFF_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win),
      .base_in(cfg_base), .lim_in(cfg_limit),
      .base_tbl(base_tbl), .lim_tbl(lim_tbl)
   );

   xlate_calc #(
      .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .VADDR_W(VADDR_W), .WIN_BITS(WIN_BITS),
      .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .BASE_W(BASE_W), .LIM_W(LIM_W),
      .PHYS_BITS(PHYS_BITS)
   ) u_calc (
      .vaddr(req_vaddr), .base_tbl(base_tbl), .lim_tbl(lim_tbl),
      .paddr(calc_paddr), .err(calc_err)
   );

   xlate_out_stage #(.W(RSP_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready), .in_data({calc_err, calc_paddr}),
      .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_word)
   );

   assign rsp_err   = rsp_word[RSP_W-1];
   assign rsp_paddr = rsp_word[PHYS_BITS-1:0];

   // R3
   low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_err || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));
   // R5
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_paddr == '0));
   // R8
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/sim_xip_addr_xlate.sv
module sim_xip_addr_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_win = '0;
   logic [11:0] cfg_base = '0;
   logic [10:0] cfg_limit = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [24:0] req_vaddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [23:0] rsp_paddr;
   logic        rsp_err;

   always #5 clk = ~clk;

   xip_addr_xlate u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
      .req_ready(req_ready), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err)
   );

   int compared = 0;
   int mismatched = 0;
   int m_base [8];
   int m_lim  [8];
   bit m_valid;
   int m_paddr;
   bit m_err;

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit v, input int a, input bit rr,
                      input bit we, input int w, input int b, input int l);
      bit exp_ready;
      int sect, idx;
      @(negedge clk);
      req_valid = v; req_vaddr = 25'(a); rsp_ready = rr;
      cfg_we = we; cfg_win = 3'(w); cfg_base = 12'(b); cfg_limit = 11'(l);
      #1;
      exp_ready = !m_valid || rr;
      chk("R8 req_ready", int'(req_ready), int'(exp_ready));
      @(posedge clk);
      if (v && exp_ready) begin
         idx  = (a >> 22) & 7;          // R2
         sect = (a >> 12) & 'h3FF;
         m_valid = 1'b1;
         m_err   = sect > m_lim[idx];   // R5
         m_paddr = m_err ? 0 : ((((sect + m_base[idx]) & 'hFFF) << 12) | (a & 'hFFF)); // R3 R4
      end else if (exp_ready) begin
         m_valid = 1'b0;
      end
      if (we) begin m_base[w] = b & 'hFFF; m_lim[w] = l & 'h7FF; end   // R6
      #1;
      chk("R7 rsp_valid", int'(rsp_valid), int'(m_valid));
      if (m_valid) begin
         chk("R3 rsp_paddr", int'(rsp_paddr), m_paddr);
         chk("R5 rsp_err", int'(rsp_err), int'(m_err));
      end
   endtask

   task automatic req(input int a);
      cyc(1'b1, a, 1'b1, 1'b0, 0, 0, 0);
   endtask

   task automatic wr(input int w, input int b, input int l);
      cyc(1'b0, 0, 1'b1, 1'b1, w, b, l);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_base[i] = (i * 'h400) % 'h1000;
         m_lim[i]  = 'h400;
      end
      m_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 rsp_valid at reset", int'(rsp_valid), 0);
      chk("R1 req_ready at reset", int'(req_ready), 1);
      @(negedge clk); rst_n = 1'b1;

      // R1 identity mapping across every window, R2 window selection
      for (int i = 0; i < 8; i++) begin
         req((i << 22) | 'h000123);
         req((i << 22) | 'h3FFFFF);
      end
      // R9 back-to-back pseudo-random stream
      for (int i = 0; i < 40; i++) req(int'($urandom) & 'h1FFFFFF);
      cyc(1'b0, 0, 1'b1, 1'b0, 0, 0, 0);

      // R4 wrap: window 3 base 0xFFF, sector 2 -> physical sector 1
      wr(3, 'hFFF, 'h3FF);
      req((3 << 22) | (2 << 12) | 'hABC);
      req((3 << 22) | (0 << 12) | 'h001);

      // R5 limit boundary: equal passes, one above fails, limit 0
      wr(5, 'h100, 'h010);
      req((5 << 22) | ('h010 << 12) | 'h777);
      req((5 << 22) | ('h011 << 12) | 'h777);
      wr(6, 'h200, 'h000);
      req((6 << 22) | 'h000FFF);
      req((6 << 22) | 'h001000);

      // R6 write and request in the same cycle: old value used, then new
      cyc(1'b1, (1 << 22) | 'h005004, 1'b1, 1'b1, 1, 'h050, 'h002);
      req((1 << 22) | 'h005004);
      req((2 << 22) | 'h005004);   // R6 other window untouched

      // R8 backpressure: hold response for several cycles
      req((7 << 22) | 'h012345);
      cyc(1'b1, (7 << 22) | 'h054321, 1'b0, 1'b0, 0, 0, 0);
      cyc(1'b1, (7 << 22) | 'h054321, 1'b0, 1'b0, 0, 0, 0);
      cyc(1'b1, (7 << 22) | 'h054321, 1'b0, 1'b0, 0, 0, 0);
      cyc(1'b1, (7 << 22) | 'h054321, 1'b1, 1'b0, 0, 0, 0);
      cyc(1'b0, 0, 1'b0, 1'b0, 0, 0, 0);
      cyc(1'b0, 0, 1'b1, 1'b0, 0, 0, 0);

      // mixed random config and traffic with random backpressure
      for (int i = 0; i < 300; i++)
         cyc(1'($urandom), int'($urandom) & 'h1FFFFFF, 1'($urandom),
             ($urandom % 8) == 0, int'($urandom % 8), int'($urandom) & 'hFFF,
             int'($urandom) & 'h7FF);
      cyc(1'b0, 0, 1'b1, 1'b0, 0, 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule